// File: doc/BRIEF.md
# Stereo DAC Staging Buffer

This block sits between a bursty audio reader and a pair of mailbox-style DAC channels. The reader delivers packed stereo words (left sample in the upper half, right sample in the lower half, both two's complement) in short bursts. The DAC side raises a ready flag whenever it can take a new code pair. The block holds up to four words and releases the oldest one each time the DAC is ready.

Each word is converted to unsigned DAC codes when it is written. Three conversions are available. The first is a plain sign flip. The second is a headroom-preserving linear scale. The third is a symmetric clamp. The last two keep every code at or below 0xFF00, which is the DAC's highest usable value. Because the conversion happens on the write side, each stored entry carries the conversion that was selected when it arrived.

A full buffer drops new words and latches a sticky overflow flag. The fill level is visible at the ports, so the reader can pace its bursts.

Top module: `dac_stage_buffer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears itself. After that edge, `fill_level` is 0, `overflow` is 0, `dac_load` is 0, and `dac_left` and `dac_right` are 0.
- R2: Words leave in the order they were accepted, first in first out, with up to 4 entries held.
- R3: A pop happens at a clock edge only when `fill_level` is non-zero and `dac_ready` is 1. Each pop lowers `fill_level` by one. Each accepted write with no pop raises it by one. `dac_load` is 1 for exactly the cycle after each pop.
- R4: A popped word drives both channels on the same edge. Bits 31:16 (converted) go to `dac_left` and bits 15:0 (converted) go to `dac_right`. Both hold their value until the next pop.
- R5: With `conv_mode` = 0, each 16-bit half s becomes s XOR 0x8000.
- R6: With `conv_mode` = 1, each half becomes ((s + 32768) * 255) >> 8. So -32768 maps to 0x0000, 0 maps to 0x7F80 and 32767 maps to 0xFEFF.
- R7: With `conv_mode` = 2 or 3, each half is clamped to the range -0x7F80 to +0x7F80 and then 0x7F80 is added. So -32768 maps to 0x0000 and 32767 maps to 0xFF00.
- R8: A write while `fill_level` is 4 is dropped, even if a pop happens in the same cycle. The dropped word never reaches the DAC. `overflow` goes to 1 and stays at 1 until reset.
- R9: A write and a pop in the same cycle, with `fill_level` between 1 and 3, leave `fill_level` unchanged.
- R10: The conversion is chosen by `conv_mode` in the cycle of the write. Changing `conv_mode` later does not alter entries already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Write strobe for `in_sample` |
| in_sample | input | 32 | Packed signed stereo word: left in 31:16, right in 15:0 |
| conv_mode | input | 2 | Conversion applied at write: 0 flip, 1 scale, 2 or 3 clamp |
| dac_ready | input | 1 | DAC can take a new code pair |
| dac_left | output | 16 | Left channel DAC code |
| dac_right | output | 16 | Right channel DAC code |
| dac_load | output | 1 | One-cycle pulse: new codes were just loaded |
| fill_level | output | 3 | Number of entries held (0 to 4) |
| overflow | output | 1 | Sticky flag: a write was dropped |

## Verification
The assertions check the following on every cycle:
- `fill_level` never exceeds the depth.
- A load pulse always follows a cycle in which the DAC was ready and the buffer held data.
- A simultaneous write and pop leaves the level stable.
- A write into a full buffer raises the overflow flag, and the flag never falls.

Some behaviours depend on data and can only be shown by the bench's scenarios:
- first-in first-out ordering;
- the exact codes of the three conversions at their extremes;
- the conversion sticking to entries written before a mode change;
- the dropped word never appearing at the DAC.

// File: rtl/dsb_pkg.sv
// dsb_pkg: shared types for the DAC staging buffer.
// Assumes nothing beyond IEEE 1800-2017.
package dsb_pkg;

    // Conversion selected on the write side.
    typedef enum logic [1:0] {
        CONV_FLIP      = 2'b00,
        CONV_SCALE     = 2'b01,
        CONV_CLAMP     = 2'b10,
        CONV_CLAMP_ALT = 2'b11
    } conv_mode_e;

endpackage

// File: rtl/dsb_convert.sv
// dsb_convert: turns a packed pair of signed samples into unsigned DAC codes.
// Assumes SAMPLE_W >= 9. The top usable code is full scale minus one LSB of
// the upper byte (0xFF00 for 16 bits); the bias is half of that value.
module dsb_convert
    import dsb_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int CHANNELS = 2
) (
    input  conv_mode_e                     mode,
    input  logic [CHANNELS*SAMPLE_W-1:0]   raw_word,
    output logic [CHANNELS*SAMPLE_W-1:0]   code_word
);

    localparam logic [SAMPLE_W-1:0] SIGN_BIT = SAMPLE_W'(1) << (SAMPLE_W - 1);
    localparam int                  TOP_CODE = (1 << SAMPLE_W) - (1 << (SAMPLE_W - 8));
    localparam logic [SAMPLE_W-1:0] BIAS_U   = SAMPLE_W'(TOP_CODE / 2);
    localparam logic signed [SAMPLE_W-1:0] POS_LIM = BIAS_U;
    localparam logic signed [SAMPLE_W-1:0] NEG_LIM = -POS_LIM;

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        logic signed [SAMPLE_W-1:0] smp;
        logic        [SAMPLE_W-1:0] flipped;
        logic        [SAMPLE_W+7:0] product;
        logic        [SAMPLE_W-1:0] scaled;
        logic signed [SAMPLE_W-1:0] limited;
        logic        [SAMPLE_W-1:0] clamped;

        assign smp     = raw_word[ch*SAMPLE_W +: SAMPLE_W];
        assign flipped = smp ^ SIGN_BIT;
        // offset value times 255, computed as x*256 - x
        assign product = ({8'd0, flipped} << 8) - {8'd0, flipped};
        assign scaled  = product[SAMPLE_W+7:8];

        // Purpose: symmetric clamp of the signed sample to the bias range.
        always_comb begin
            if (smp > POS_LIM)      limited = POS_LIM;
            else if (smp < NEG_LIM) limited = NEG_LIM;
            else                    limited = smp;
        end

        assign clamped = $unsigned(limited) + BIAS_U;

        // Purpose: pick the code for this channel from the selected mode.
        always_comb begin
            unique case (mode)
                CONV_FLIP:  code_word[ch*SAMPLE_W +: SAMPLE_W] = flipped;
                CONV_SCALE: code_word[ch*SAMPLE_W +: SAMPLE_W] = scaled;
                default:    code_word[ch*SAMPLE_W +: SAMPLE_W] = clamped;
            endcase
        end
    end

endmodule

// File: rtl/dsb_store.sv
// dsb_store: small circular store with a write index, a read index and a
// fill level. Pops when the drain side is ready and data is held. Writes into
// a full store are dropped and latch a sticky overflow flag.
// Assumes DEPTH >= 2. Synchronous active-low reset.
module dsb_store #(
    parameter int DEPTH  = 4,
    parameter int WORD_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [WORD_W-1:0] push_word,
    input  logic              drain_ok,
    output logic              pop,
    output logic [WORD_W-1:0] head_word,
    output logic [LVL_W-1:0]  level,
    output logic              overflow
);

    logic [WORD_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wr_idx;
    logic [PTR_W-1:0]  rd_idx;
    logic              full;
    logic              push;

    assign full      = (level == LVL_W'(DEPTH));
    assign push      = push_req && !full;
    assign pop       = drain_ok && (level != '0);
    assign head_word = slots[rd_idx];

    // Purpose: advance an index by one with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] idx);
        return (idx == PTR_W'(DEPTH - 1)) ? '0 : idx + PTR_W'(1);
    endfunction

    // Purpose: store an accepted word in the slot under the write index.
    always_ff @(posedge clk) begin
        if (push) slots[wr_idx] <= push_word;
    end

    // Purpose: update the indices, the fill level and the overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx   <= '0;
            rd_idx   <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push) wr_idx <= bump(wr_idx);
            if (pop)  rd_idx <= bump(rd_idx);
            unique case ({push, pop})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
            if (push_req && full) overflow <= 1'b1;
        end
    end

    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    a_r9_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(level));

    a_r8_full_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full) |=> overflow);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

// File: rtl/dsb_drain.sv
// dsb_drain: output register stage. Loads both channel codes from the head
// word on a pop and pulses a load strobe for one cycle.
// Assumes the upper channel of the word is the left DAC.
module dsb_drain #(
    parameter int SAMPLE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pop,
    input  logic [2*SAMPLE_W-1:0] head_word,
    output logic [SAMPLE_W-1:0]   left_code,
    output logic [SAMPLE_W-1:0]   right_code,
    output logic                  load
);

    // Purpose: capture the head word into both DAC channels on a pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_code  <= '0;
            right_code <= '0;
            load       <= 1'b0;
        end else begin
            load <= pop;
            if (pop) begin
                left_code  <= head_word[2*SAMPLE_W-1:SAMPLE_W];
                right_code <= head_word[SAMPLE_W-1:0];
            end
        end
    end

    a_r4_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> ($stable(left_code) && $stable(right_code)));

endmodule

// File: rtl/dac_stage_buffer.sv
// dac_stage_buffer: four-entry staging buffer between a bursty stereo sample
// reader and a pair of ready-driven DAC channels. Converts on the write side,
// drains on DAC readiness.
// Assumes in_sample is two's complement, left half on top.
module dac_stage_buffer #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 4,
    localparam int WORD_W  = 2 * SAMPLE_W,
    localparam int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_sample,
    input  logic [1:0]          conv_mode,
    input  logic                dac_ready,
    output logic [SAMPLE_W-1:0] dac_left,
    output logic [SAMPLE_W-1:0] dac_right,
    output logic                dac_load,
    output logic [LVL_W-1:0]    fill_level,
    output logic                overflow
);

    logic [WORD_W-1:0] coded;
    logic [WORD_W-1:0] head;
    logic              pop;

    dsb_convert #(.SAMPLE_W(SAMPLE_W), .CHANNELS(2)) i_convert (
        .mode      (dsb_pkg::conv_mode_e'(conv_mode)),
        .raw_word  (in_sample),
        .code_word (coded)
    );

    dsb_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (in_valid),
        .push_word (coded),
        .drain_ok  (dac_ready),
        .pop       (pop),
        .head_word (head),
        .level     (fill_level),
        .overflow  (overflow)
    );

    dsb_drain #(.SAMPLE_W(SAMPLE_W)) i_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop        (pop),
        .head_word  (head),
        .left_code  (dac_left),
        .right_code (dac_right),
        .load       (dac_load)
    );

    a_r3_load_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |-> ($past(dac_ready) && ($past(fill_level) != '0)));

    a_r3_level_drops_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_ready && fill_level != '0 && !in_valid) |=> (fill_level == $past(fill_level) - LVL_W'(1)));

endmodule

// File: tb/test_dac_stage_buffer.sv
module test_dac_stage_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_sample = '0;
    logic [1:0]  conv_mode = '0;
    logic        dac_ready = 1'b0;
    logic [15:0] dac_left, dac_right;
    logic        dac_load;
    logic [2:0]  fill_level;
    logic        overflow;

    always #4 clk = ~clk;  // 125 MHz

    dac_stage_buffer i_dac_stage_buffer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .conv_mode(conv_mode), .dac_ready(dac_ready), .dac_left(dac_left),
        .dac_right(dac_right), .dac_load(dac_load), .fill_level(fill_level),
        .overflow(overflow)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_tag = "R1";

    // reference model state
    logic [31:0] mq[$];
    logic        m_load = 0;
    logic [15:0] m_left = 0, m_right = 0;
    logic        m_ovf = 0;

    function automatic logic [15:0] ref_conv(input int mode, input logic [15:0] h);
        int s;
        s = $signed(h);
        if (mode == 0) return h ^ 16'h8000;
        if (mode == 1) return 16'(((s + 32768) * 255) / 256);
        if (s > 32640)  s = 32640;
        if (s < -32640) s = -32640;
        return 16'(s + 32640);
    endfunction

    function automatic logic [31:0] pk(input int l, input int r);
        return {l[15:0], r[15:0]};
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(fill_level == 3'(mq.size()), "level (R3)", fill_level, mq.size());
        chk(dac_load == m_load, "load strobe (R3)", dac_load, m_load);
        chk(dac_left == m_left, "left code (R4)", dac_left, m_left);
        chk(dac_right == m_right, "right code (R4)", dac_right, m_right);
        chk(overflow == m_ovf, "overflow (R8)", overflow, m_ovf);
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit v, input logic [31:0] d, input int m, input bit rdy);
        bit full;
        bit pop;
        in_valid  = v;
        in_sample = d;
        conv_mode = 2'(m);
        dac_ready = rdy;
        @(posedge clk);
        full = (mq.size() == 4);
        pop  = rdy && (mq.size() != 0);
        m_load = pop;
        if (pop) begin
            m_left  = mq[0][31:16];
            m_right = mq[0][15:0];
            void'(mq.pop_front());
        end
        if (v) begin
            if (full) m_ovf = 1;
            else mq.push_back({ref_conv(m, d[31:16]), ref_conv(m, d[15:0])});
        end
        @(negedge clk);
        compare();
    endtask

    task automatic idle_drain(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_tag = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare();
        rst_n = 1'b1;

        // R5 and R2: flip mode, burst then drain in order
        cur_tag = "R5 R2";
        step(1, pk(16'h0001, 16'hFFFF), 0, 0);
        step(1, pk(16'h8000, 16'h7FFF), 0, 0);
        step(1, pk(16'h1234, 16'hABCD), 0, 0);
        idle_drain(5);

        // R6: scale mode extremes and midpoint
        cur_tag = "R6";
        step(1, pk(-32768, 0), 1, 0);
        step(1, pk(0, 32767), 1, 0);
        step(1, pk(16'h1234, -100), 1, 0);
        idle_drain(4);

        // R7: clamp mode, both encodings
        cur_tag = "R7";
        step(1, pk(32767, -32768), 2, 0);
        step(1, pk(16'h7F80, -32640), 2, 0);
        step(1, pk(100, -100), 3, 0);
        step(1, pk(32641, -32641), 3, 0);
        idle_drain(5);

        // R10: mode changes while entries are held
        cur_tag = "R10";
        step(1, pk(16'h4000, -16384), 0, 0);
        step(1, pk(16'h4000, -16384), 1, 0);
        step(1, pk(16'h4000, -16384), 2, 0);
        step(0, '0, 0, 0);
        step(0, '0, 1, 1);
        step(0, '0, 2, 1);
        step(0, '0, 0, 1);
        step(0, '0, 1, 1);

        // R9: write and pop together keep the level
        cur_tag = "R9";
        step(1, pk(1, 2), 0, 1);
        for (int i = 0; i < 6; i++) step(1, pk(i * 37, -i * 91), i % 4, 1);
        idle_drain(3);

        // R8: overflow drops words, sticky, including write with pop at full
        cur_tag = "R8";
        for (int i = 0; i < 6; i++) step(1, pk(16'h0100 * i, 16'h0011 * i), 0, 0);
        step(1, pk(16'h7777, 16'h7777), 0, 1);
        idle_drain(6);

        // R2: random mix
        cur_tag = "R2 random";
        for (int i = 0; i < 400; i++)
            step(1'($urandom_range(0, 1)), $urandom(), int'($urandom_range(0, 3)),
                 1'($urandom_range(0, 2) != 0));
        idle_drain(6);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule